// File: doc/BRIEF.md
# Word-Fed SHA-224/256 Hash Engine

This block computes SHA-256 or SHA-224 digests of messages that a processor pushes in one 32-bit word at a time through a small register window. Software first loads a context: eight chaining words and a 64-bit running byte count. That context may be the standard initial values with a zero count, or a state saved from an earlier partial hash. Software then writes message words. Control flags in the control register mark the word that closes a 64-byte block and the block that ends the message. A two-bit field gives how many bytes of the closing word are valid.

When the message ends, the engine appends the padding itself. It adds the marker byte, the zero fill and the 64-bit bit length, and it runs a second padding block when the tail leaves no room for the length. Each block takes 64 rounds at one round per clock. While a block is in progress a busy flag reads high and data and context writes are dropped. A pulse bit copies the chaining state into a readback window of eight words.

Top module: `sha2r_engine`

## Requirements
- R1: After reset the control register (address 0) reads 0 and every readback word (addresses 8 to 15) reads 0.
- R2: A data write (address 1) is taken only when control bit 3 and bit 0 are both 1 and the mode field (bits 17:16) is 2 (SHA-256) or 3 (SHA-224). In any other setting the write leaves the hash unchanged.
- R3: Context writes to address 2 fill, in order, chaining words H7 down to H0, then the low and then the high half of the byte count. Writing control bit 6 restarts this sequence and the word position. Writes past the tenth are dropped.
- R4: A data word carries message bytes in big-endian order (bits 31:24 first). A data write with bit 21 set and bit 20 clear closes a full 16-word block and starts its compression.
- R5: A data write with bits 21 and 20 set is the final word. Only its leading (bits 19:18)+1 bytes count, and the rest of the word is discarded. The engine then places byte 0x80, zero fill and the 64-bit big-endian bit length to complete the message.
- R6: When the 0x80 marker lands in word 14 or later of the final block, the engine compresses one extra block holding only zeros (plus the marker if it did not fit) and the length.
- R7: Control bit 31 reads 1 from the acceptance of a block-closing word until the last pending block is folded into the state. Data and context writes made while it is 1 are ignored.
- R8: A control write with bit 22 set clears bits 21 and 20. Bit 22 always reads back 0.
- R9: A control write with bit 7 set copies H0..H7 to readback addresses 8..15. The window holds its value until the next such write. If the written mode is 3, address 15 reads 0.
- R10: A non-final block keeps the busy flag high for exactly 65 clock cycles after the cycle that accepts its closing word (64 rounds plus one fold cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The assertions watch the gating rules on every cycle. While busy or in an unsupported mode, a data write leaves the byte count unchanged, and a context write while busy leaves the load position unchanged. They also check that an acknowledge clears both flags, that the readback window changes only on a latch pulse, that the round counter stops after its last round, and that the word window is never written and shifted in the same cycle. The correctness of the digests can only be shown by the bench scenarios, which compare against published digests. These scenarios cover a short final word, a tail that forces an extra padding block, and a hash resumed from a restored context. The bench scenarios also show the exact busy length and the zeroed eighth word in SHA-224 mode.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;
  typedef logic [31:0]      word_t;
  typedef logic [7:0][31:0] hvec_t;

  localparam int NUM_ROUNDS = 64;

  localparam word_t KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t bsig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bsig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t ssig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t major(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha2r_sched.sv
module sha2r_sched
  import sha2r_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  word_t                    wdata,
  input  logic                     shift,
  output word_t                    w_head
);
  localparam int IDXW = $clog2(DEPTH);

  logic [DEPTH-1:0][31:0] win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (shift) begin
      for (int i = 0; i < DEPTH - 1; i++) win_d[i] = win_q[i+1];
      win_d[DEPTH-1] = ssig1(win_q[DEPTH-2]) + win_q[DEPTH-7] + ssig0(win_q[1]) + win_q[0];
    end else if (we) begin
      win_d[widx] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else if (shift || we) win_q <= win_d;
  end

  assign w_head = win_q[0];

  logic [IDXW-1:0] unused_idx;
  assign unused_idx = widx;

  // R4: loading and expanding never collide
  p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(we && shift));
endmodule

// File: rtl/sha2r_round.sv
module sha2r_round
  import sha2r_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  hvec_t h_init,
  input  word_t w_t,
  output logic  active,
  output logic  last,
  output hvec_t work
);
  localparam int CW = $clog2(ROUNDS);

  logic [CW-1:0] t_q, t_d;
  logic          act_q, act_d;
  hvec_t         v_q, v_d;
  word_t         t1, t2;

  assign last = act_q && (t_q == CW'(ROUNDS - 1));

  always_comb begin
    t1    = v_q[7] + bsig1(v_q[4]) + choose(v_q[4], v_q[5], v_q[6]) + KTAB[t_q] + w_t;
    t2    = bsig0(v_q[0]) + major(v_q[0], v_q[1], v_q[2]);
    v_d   = v_q;
    t_d   = t_q;
    act_d = act_q;
    if (go) begin
      v_d   = h_init;
      t_d   = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      v_d[0] = t1 + t2;
      v_d[1] = v_q[0];
      v_d[2] = v_q[1];
      v_d[3] = v_q[2];
      v_d[4] = v_q[3] + t1;
      v_d[5] = v_q[4];
      v_d[6] = v_q[5];
      v_d[7] = v_q[6];
      t_d    = t_q + 1'b1;
      if (last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      t_q   <= '0;
      act_q <= 1'b0;
    end else if (go || act_q) begin
      v_q   <= v_d;
      t_q   <= t_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign work   = v_q;

  // R10: the round sequence ends after its final round
  p_round_stop_r10: assert property (@(posedge clk) disable iff (!rst_n) last |=> !active);
  // R10: a new block is never started on top of a running one
  p_go_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) go |-> !active);
endmodule

// File: rtl/sha2r_engine.sv
module sha2r_engine
  import sha2r_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 16,
  parameter int ROUNDS = NUM_ROUNDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTX  = ADDR_W'(2);
  localparam logic [IDXW:0]     LEN_LIMIT = (IDXW+1)'(DEPTH - 3);
  localparam logic [3:0]        CTX_WORDS = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_PAD, ST_COMP, ST_FOLD} st_e;

  st_e              state_q, state_d;
  logic             lw_q, lw_d, lb_q, lb_d, en_q, en_d, dp_q, dp_d;
  logic [1:0]       cnt_q, cnt_d, mode_q, mode_d;
  logic [IDXW-1:0]  widx_q, widx_d, padj_q, padj_d;
  logic             pend_q, pend_d, here_q, here_d, extra_q, extra_d;
  logic [63:0]      len_q, len_d;
  logic [3:0]       ptr_q, ptr_d;
  hvec_t            h_q, h_d, rd_q, rd_d;

  logic             ctl_wr, dat_wr, ctx_wr, idle, accept, final_w, go;
  logic [2:0]       nbytes, hsel;
  logic [IDXW:0]    mpos;
  logic [63:0]      len_bits;
  word_t            fin_word, pad_word, s_data, w_head;
  logic             s_we, rnd_active, rnd_last;
  logic [IDXW-1:0]  s_idx;
  hvec_t            work;

  assign ctl_wr   = bus_wr && (bus_addr == A_CTL);
  assign dat_wr   = bus_wr && (bus_addr == A_DATA);
  assign ctx_wr   = bus_wr && (bus_addr == A_CTX);
  assign idle     = (state_q == ST_IDLE);
  assign accept   = dat_wr && idle && en_q && dp_q && mode_q[1];
  assign final_w  = lw_q && lb_q;
  assign nbytes   = final_w ? ({1'b0, cnt_q} + 3'd1) : 3'd4;
  assign len_bits = {len_q[60:0], 3'b000};
  assign hsel     = 3'd7 - ptr_q[2:0];
  assign mpos     = (cnt_q != 2'd3) ? {1'b0, widx_q} : ({1'b0, widx_q} + 1'b1);

  always_comb begin
    case (cnt_q)
      2'd0:    fin_word = {bus_wdata[31:24], 8'h80, 16'h0000};
      2'd1:    fin_word = {bus_wdata[31:16], 8'h80, 8'h00};
      2'd2:    fin_word = {bus_wdata[31:8], 8'h80};
      default: fin_word = bus_wdata;
    endcase
    if (here_q && (padj_q == IDXW'(DEPTH - 2)))      pad_word = len_bits[63:32];
    else if (here_q && (padj_q == IDXW'(DEPTH - 1))) pad_word = len_bits[31:0];
    else if (pend_q)                                  pad_word = 32'h8000_0000;
    else                                              pad_word = '0;
  end

  assign s_we   = accept || (state_q == ST_PAD);
  assign s_idx  = (state_q == ST_PAD) ? padj_q : widx_q;
  assign s_data = (state_q == ST_PAD) ? pad_word : (final_w ? fin_word : bus_wdata);

  always_comb begin
    state_d = state_q;
    lw_d = lw_q; lb_d = lb_q; cnt_d = cnt_q; mode_d = mode_q; en_d = en_q; dp_d = dp_q;
    widx_d = widx_q; padj_d = padj_q; pend_d = pend_q; here_d = here_q; extra_d = extra_q;
    len_d = len_q; ptr_d = ptr_q; h_d = h_q; rd_d = rd_q;
    go = 1'b0;

    if (ctl_wr) begin
      lw_d   = bus_wdata[21];
      lb_d   = bus_wdata[20];
      cnt_d  = bus_wdata[19:18];
      mode_d = bus_wdata[17:16];
      en_d   = bus_wdata[3];
      dp_d   = bus_wdata[0];
      if (bus_wdata[22]) begin
        lw_d = 1'b0;
        lb_d = 1'b0;
      end
      if (bus_wdata[6]) begin
        ptr_d  = '0;
        widx_d = '0;
      end
      if (bus_wdata[7]) begin
        rd_d = h_q;
        if (bus_wdata[17:16] == 2'd3) rd_d[7] = '0;
      end
    end

    if (ctx_wr && idle && (ptr_q < CTX_WORDS)) begin
      if (ptr_q < 4'd8)       h_d[hsel]    = bus_wdata;
      else if (ptr_q == 4'd8) len_d[31:0]  = bus_wdata;
      else                    len_d[63:32] = bus_wdata;
      ptr_d = ptr_q + 4'd1;
    end

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          len_d  = len_q + 64'(nbytes);
          widx_d = widx_q + 1'b1;
          if (final_w) begin
            widx_d  = '0;
            pend_d  = (cnt_q == 2'd3);
            here_d  = (mpos <= LEN_LIMIT);
            extra_d = (mpos > LEN_LIMIT);
            padj_d  = widx_q + 1'b1;
            if (widx_q == IDXW'(DEPTH - 1)) begin
              state_d = ST_COMP;
              go      = 1'b1;
            end else begin
              state_d = ST_PAD;
            end
          end else if (lw_q) begin
            widx_d  = '0;
            extra_d = 1'b0;
            state_d = ST_COMP;
            go      = 1'b1;
          end
        end
      end
      ST_PAD: begin
        if (pend_q && !(here_q && (padj_q >= IDXW'(DEPTH - 2)))) pend_d = 1'b0;
        padj_d = padj_q + 1'b1;
        if (padj_q == IDXW'(DEPTH - 1)) begin
          state_d = ST_COMP;
          go      = 1'b1;
        end
      end
      ST_COMP: begin
        if (rnd_last) state_d = ST_FOLD;
      end
      default: begin
        for (int i = 0; i < 8; i++) h_d[i] = h_q[i] + work[i];
        if (extra_q) begin
          state_d = ST_PAD;
          padj_d  = '0;
          here_d  = 1'b1;
          extra_d = 1'b0;
        end else begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lw_q <= 1'b0; lb_q <= 1'b0; cnt_q <= '0; mode_q <= '0; en_q <= 1'b0; dp_q <= 1'b0;
      widx_q <= '0; padj_q <= '0; pend_q <= 1'b0; here_q <= 1'b0; extra_q <= 1'b0;
      len_q <= '0; ptr_q <= '0; h_q <= '0; rd_q <= '0;
    end else begin
      state_q <= state_d;
      lw_q <= lw_d; lb_q <= lb_d; cnt_q <= cnt_d; mode_q <= mode_d; en_q <= en_d; dp_q <= dp_d;
      widx_q <= widx_d; padj_q <= padj_d; pend_q <= pend_d; here_q <= here_d; extra_q <= extra_d;
      len_q <= len_d; ptr_q <= ptr_d; h_q <= h_d;
      if (ctl_wr && bus_wdata[7]) rd_q <= rd_d;
    end
  end

  sha2r_sched #(.DEPTH(DEPTH)) u_sched (
    .clk(clk), .rst_n(rst_n), .we(s_we), .widx(s_idx), .wdata(s_data),
    .shift(rnd_active), .w_head(w_head)
  );

  sha2r_round #(.ROUNDS(ROUNDS)) u_round (
    .clk(clk), .rst_n(rst_n), .go(go), .h_init(h_q), .w_t(w_head),
    .active(rnd_active), .last(rnd_last), .work(work)
  );

  always_comb begin
    if (bus_addr == A_CTL)
      bus_rdata = {!idle, 9'b0, lw_q, lb_q, cnt_q, mode_q, 12'b0, en_q, 2'b0, dp_q};
    else if (bus_addr[ADDR_W-1])
      bus_rdata = rd_q[bus_addr[2:0]];
    else
      bus_rdata = '0;
  end

  // R2: unsupported mode leaves the byte count untouched
  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !mode_q[1]) |=> $stable(len_q));
  // R3: the context position never runs past the ten words
  p_ptr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n) ptr_q <= CTX_WORDS);
  // R7: data written while busy is dropped
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idle) |=> $stable(len_q));
  // R7: context written while busy is dropped
  p_ctx_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && !idle) |=> $stable(ptr_q));
  // R8: acknowledge clears both block flags
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[22]) |=> (!lw_q && !lb_q));
  // R9: readback window moves only on a latch pulse
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && bus_wdata[7]) |=> $stable(rd_q));
endmodule

// File: tb/sha2r_engine_tb.sv
`timescale 1ns/1ps
module sha2r_engine_tb;
  logic        clk, rst_n, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  mode_b;
  logic [7:0]  mbuf [128];
  logic [31:0] got [8];
  int          n_chk, n_fail;
  bit          done_flag;

  sha2r_engine u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctlv(input bit lw, input bit lb, input logic [1:0] cnt);
    return {10'b0, lw, lb, cnt, mode_b, 12'h0, 4'b1001};
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd0, v);
      if (!v[31]) return;
      @(negedge clk);
    end
  endtask

  task automatic load_ctx(input logic [31:0] h [8], input logic [31:0] lo);
    wr(4'd0, ctlv(0, 0, 0) | 32'h40);
    for (int i = 7; i >= 0; i--) wr(4'd2, h[i]);
    wr(4'd2, lo);
    wr(4'd2, 32'h0);
  endtask

  task automatic load_iv(input bit is224);
    logic [31:0] iv [8];
    if (is224) iv = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                      32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
    else       iv = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    load_ctx(iv, 32'h0);
  endtask

  // feeds mbuf[start +: n]; fin marks the message end; inj writes during busy
  task automatic feed(input int start, input int n, input bit fin, input bit inj);
    int nw, rem;
    logic [31:0] w, v;
    nw = (n + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      rem = n - 4 * i;
      w = 32'hA5A5A5A5;
      for (int b = 0; b < 4; b++) if (b < rem) w[31-8*b -: 8] = mbuf[start + 4*i + b];
      if (fin && i == nw - 1) begin
        wr(4'd0, ctlv(1, 1, 2'((rem > 4 ? 4 : rem) - 1)));
        wr(4'd1, w);
        if (inj) begin
          rd(4'd0, v);
          chk(v[31] == 1'b1, "R7 busy after final word", 256'(v[31]), 256'(1));
          wr(4'd1, 32'hDEADBEEF);
          wr(4'd2, 32'h12345678);
        end
        wait_idle();
        wr(4'd0, ctlv(0, 0, 0) | 32'h0040_0000);
      end else if (i % 16 == 15) begin
        wr(4'd0, ctlv(1, 0, 0));
        wr(4'd1, w);
        wait_idle();
        wr(4'd0, ctlv(0, 0, 0) | 32'h0040_0000);
      end else begin
        wr(4'd1, w);
      end
    end
  endtask

  task automatic grab();
    wr(4'd0, ctlv(0, 0, 0) | 32'h80);
    for (int i = 0; i < 8; i++) rd(4'(8 + i), got[i]);
  endtask

  function automatic logic [255:0] pack8(input logic [31:0] a [8]);
    return {a[0], a[1], a[2], a[3], a[4], a[5], a[6], a[7]};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    logic [255:0] all;
    rd(4'd0, v);
    chk(v == 32'h0, "R1 control after reset", 256'(v), 256'(0));
    all = '0;
    for (int i = 0; i < 8; i++) begin rd(4'(8 + i), v); all = (all << 32) | 256'(v); end
    chk(all == '0, "R1 readback after reset", all, 256'(0));
  endtask

  task automatic set_abc();
    mbuf[0] = 8'h61; mbuf[1] = 8'h62; mbuf[2] = 8'h63;
  endtask

  task automatic t_abc256();
    logic [31:0] v;
    logic [31:0] e [8];
    e = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
          32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    mode_b = 2'd2; set_abc(); load_iv(0);
    feed(0, 3, 1, 0);
    rd(4'd8, v);
    chk(v == 32'h0, "R9 window unchanged before latch", 256'(v), 256'(0));
    grab();
    chk(pack8(got) == pack8(e), "R5 short final word digest", pack8(got), pack8(e));
  endtask

  task automatic t_abc224();
    logic [31:0] e [8];
    e = '{32'h23097d22, 32'h3405d822, 32'h8642a477, 32'hbda255b3,
          32'h2aadbce4, 32'hbda0b3f7, 32'he36c9da7, 32'h0};
    mode_b = 2'd3; set_abc(); load_iv(1);
    feed(0, 3, 1, 0);
    grab();
    chk(pack8(got) == pack8(e), "R5 SHA-224 digest", pack8(got), pack8(e));
    chk(got[7] == 32'h0, "R9 eighth word zero in 224 mode", 256'(got[7]), 256'(0));
  endtask

  task automatic t_extra_block();
    logic [31:0] e [8];
    e = '{32'h248d6a61, 32'hd20638b8, 32'he5c02693, 32'h0c3e6039,
          32'ha33ce459, 32'h64ff2167, 32'hf6ecedd4, 32'h19db06c1};
    for (int i = 0; i < 14; i++) for (int j = 0; j < 4; j++) mbuf[4*i + j] = 8'(8'h61 + i + j);
    mode_b = 2'd2; load_iv(0);
    feed(0, 56, 1, 0);
    grab();
    chk(pack8(got) == pack8(e), "R6 extra padding block digest", pack8(got), pack8(e));
  endtask

  task automatic t_resume();
    logic [31:0] e [8];
    logic [31:0] mid [8];
    logic [31:0] v, w;
    int busy_n;
    e = '{32'hcf5b16a7, 32'h78af8380, 32'h036ce59e, 32'h7b049237,
          32'h0b249b11, 32'he8f07a51, 32'hafac4503, 32'h7afee9d1};
    for (int i = 0; i < 14; i++) for (int j = 0; j < 8; j++) mbuf[8*i + j] = 8'(8'h61 + i + j);
    mode_b = 2'd2; load_iv(0);
    feed(0, 60, 0, 0);
    wr(4'd0, ctlv(1, 0, 0));
    w = {mbuf[60], mbuf[61], mbuf[62], mbuf[63]};
    wr(4'd1, w);
    busy_n = 0;
    for (int i = 0; i < 200; i++) begin
      rd(4'd0, v);
      if (!v[31]) break;
      busy_n++;
      @(negedge clk);
    end
    chk(busy_n == 65, "R10 busy cycles for one block", 256'(busy_n), 256'(65));
    wr(4'd0, ctlv(0, 0, 0) | 32'h0040_0000);
    grab();
    mid = got;
    wr(4'd0, 32'h0);
    load_ctx(mid, 32'd64);
    feed(64, 48, 1, 0);
    grab();
    chk(pack8(got) == pack8(e), "R3 R4 resumed two-block digest", pack8(got), pack8(e));
  endtask

  task automatic t_ignore();
    logic [31:0] e [8];
    e = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
          32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    mode_b = 2'd2; set_abc(); load_iv(0);
    wr(4'd0, 32'h0001_0009);
    wr(4'd1, 32'h11111111);
    wr(4'd0, 32'h0002_0008);
    wr(4'd1, 32'h22222222);
    wr(4'd0, 32'h0002_0001);
    wr(4'd1, 32'h33333333);
    feed(0, 3, 1, 0);
    grab();
    chk(pack8(got) == pack8(e), "R2 gated writes ignored", pack8(got), pack8(e));
  endtask

  task automatic t_busy();
    logic [31:0] e [8];
    e = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
          32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    mode_b = 2'd2; set_abc(); load_iv(0);
    feed(0, 3, 1, 1);
    grab();
    chk(pack8(got) == pack8(e), "R7 writes while busy ignored", pack8(got), pack8(e));
  endtask

  task automatic t_ack();
    logic [31:0] v;
    mode_b = 2'd2;
    wr(4'd0, ctlv(1, 1, 2'd2));
    rd(4'd0, v);
    chk(v[21:20] == 2'b11, "R8 flags set before ack", 256'(v[21:20]), 256'(3));
    wr(4'd0, ctlv(1, 1, 2'd2) | 32'h0040_0000);
    rd(4'd0, v);
    chk(v[22:20] == 3'b000, "R8 ack clears flags", 256'(v[22:20]), 256'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done_flag = 0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; mode_b = 2'd2;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abc256();
    t_abc224();
    t_extra_block();
    t_resume();
    t_ignore();
    t_busy();
    t_ack();
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule